// File: doc/BRIEF.md
# Eight-bit addressable latch with demultiplex mode

The block stores eight single-bit values, each selected by a 3-bit address. It has one serial data input and two active-low controls, a clear control and a write-enable control. Together the two controls pick one of four modes. Addressed write updates one bit. Hold freezes all bits. Demultiplex drives the addressed bit to the data value and clears every other bit. Clear zeroes all bits. The eight stored bits appear in parallel and non-inverted on the output.

Storage is built from rising-edge registers, so the design stays synthesizable. Each mode acts on the clock edge at which it is sampled, and the output shows the result from that edge onward. The address should only change by more than one bit while in hold. In this clocked model a write always goes to the address sampled at the edge, so no transient wrong bit can be selected.

Top module: `bit_latch_demux`

## Requirements
- R1: While rst_ni is low, q_o is all zero, asynchronously.
- R2: The mode is decoded from {clr_ni, en_ni}. 2'b10 is write, 2'b11 is hold, 2'b00 is demultiplex and 2'b01 is clear. In write mode, bit q_o[addr_i] takes data_i at the clock edge.
- R3: In write mode, every bit other than q_o[addr_i] keeps its previous value across the edge.
- R4: In hold mode, q_o does not change, whatever addr_i and data_i are.
- R5: In demultiplex mode, after the edge q_o[addr_i] equals data_i and all other bits are zero.
- R6: In clear mode, q_o becomes all zero after the edge, whatever addr_i and data_i are.
- R7: The pattern left by demultiplex mode is stored, so a following hold keeps it unchanged.
- R8: A mode acts on exactly one edge. The output reflects it after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_ni | input | 1 | Active-low clear control, half of the mode select |
| en_ni | input | 1 | Active-low enable control, half of the mode select |
| addr_i | input | 3 | Bit address |
| data_i | input | 1 | Data bit |
| q_o | output | 8 | Stored bits, non-inverting |

## Verification
The outputs are the storage itself, so any corrupted bit is visible on q_o immediately after the edge that produced it. It stays visible until a write, demultiplex or clear overwrites it. The most likely faults are a write disturbing a neighbouring bit, a swapped mode code, or a demultiplex that fails to clear the other bits. Each of these shows as a mismatch one cycle after the offending input. The sweep runs every mode, address and data combination against a reference model, starting from varied stored patterns, and compares the full output word after every edge.

// File: rtl/bld_pkg.sv
package bld_pkg;
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } mode_e;
endpackage

// File: rtl/bld_mode_dec.sv
module bld_mode_dec
  import bld_pkg::*;
(
  input  logic  clr_ni,
  input  logic  en_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({clr_ni, en_ni})
      2'b10:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/bld_addr_dec.sv
module bld_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NBITS-1:0]  sel_o
);
  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/bld_cell.sv
module bld_cell
  import bld_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  sel_i,
  input  logic  data_i,
  output logic  q_o
);
  logic q_d;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: q_d = sel_i ? data_i : q_o;
      MODE_DEMUX: q_d = sel_i & data_i;
      MODE_CLEAR: q_d = 1'b0;
      default:    q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/bit_latch_demux.sv
module bit_latch_demux
  import bld_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  output logic [NBITS-1:0]  q_o
);
  mode_e            mode;
  logic [NBITS-1:0] sel;

  bld_mode_dec u_mode (
    .clr_ni (clr_ni),
    .en_ni  (en_ni),
    .mode_o (mode)
  );

  bld_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    bld_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .sel_i  (sel[i]),
      .data_i (data_i),
      .q_o    (q_o[i])
    );
  end
endmodule

// File: rtl/bld_chk.sv
module bld_chk #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_ni,
  input logic              en_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data_i,
  input logic [NBITS-1:0]  q_o
);
  logic [NBITS-1:0] onehot;
  logic wr, hd, dm, cl;
  assign onehot = NBITS'(1) << addr_i;
  assign wr = clr_ni & ~en_ni;
  assign hd = clr_ni & en_ni;
  assign dm = ~clr_ni & ~en_ni;
  assign cl = ~clr_ni & en_ni;

  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> q_o == '0);
  a_r2_write_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> q_o[$past(addr_i)] == $past(data_i));
  a_r3_write_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> (q_o & ~$past(onehot)) == ($past(q_o) & ~$past(onehot)));
  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hd |=> $stable(q_o));
  a_r5_demux_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm |=> q_o == ($past(data_i) ? $past(onehot) : '0));
  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl |=> q_o == '0);
  a_r5_demux_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm |=> $onehot0(q_o));
endmodule

bind bit_latch_demux bld_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .en_ni  (en_ni),
  .addr_i (addr_i),
  .data_i (data_i),
  .q_o    (q_o)
);

// File: tb/bit_latch_demux_tb.sv
module bit_latch_demux_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_ni = 1'b1;
  logic       en_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic       data_i = 1'b0;
  logic [7:0] q_o;
  logic [7:0] mdl = '0;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  bit_latch_demux u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_ni(en_ni),
    .addr_i(addr_i), .data_i(data_i), .q_o(q_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected %b", req, act, exp);
    end
  endtask

  // mode code m = {clr_ni, en_ni}: 2=write 3=hold 0=demux 1=clear
  task automatic step(input logic [1:0] m, input logic [2:0] a, input logic d);
    logic [7:0] prev;
    logic [7:0] oh;
    @(negedge clk_i);
    {clr_ni, en_ni} = m;
    addr_i = a;
    data_i = d;
    prev = mdl;
    oh = 8'(1) << a;
    #1 chk("R8 no change before edge", q_o, prev);
    @(posedge clk_i);
    case (m)
      2'b10: mdl = d ? (prev | oh) : (prev & ~oh);
      2'b11: mdl = prev;
      2'b00: mdl = d ? oh : 8'h00;
      default: mdl = 8'h00;
    endcase
    @(negedge clk_i);
    case (m)
      2'b10: begin
        chk("R2 write addressed bit", 8'(q_o[a]), 8'(d));
        chk("R3 write others kept", q_o & ~oh, prev & ~oh);
      end
      2'b11: chk("R4 hold", q_o, prev);
      2'b00: chk("R5 demux", q_o, mdl);
      default: chk("R6 clear", q_o, 8'h00);
    endcase
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset", q_o, 8'h00);
    rst_ni = 1'b1;
    // build a mixed pattern
    for (int i = 0; i < 8; i++) step(2'b10, 3'(i), 1'((8'hA5 >> i) & 1));
    chk("R2 pattern load", q_o, 8'hA5);
    for (int rep = 0; rep < 3; rep++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 8; a++)
          for (int d = 0; d < 2; d++) begin
            if (m != 2 && (a + d) % 3 == 0)
              for (int k = 0; k < 8; k++) step(2'b10, 3'(k), 1'(((rep * 37 + a * 11 + k) >> 1) & 1));
            step(2'(m), 3'(a), 1'(d));
          end
    // R7: demux result persists across holds
    for (int a = 0; a < 8; a++) begin
      step(2'b00, 3'(a), 1'b1);
      for (int h = 0; h < 3; h++) step(2'b11, 3'(7 - h), 1'(h));
      chk("R7 demux kept by hold", q_o, 8'(1) << a);
    end
    // R1: asynchronous reset mid-cycle
    step(2'b10, 3'd3, 1'b1);
    @(negedge clk_i);
    {clr_ni, en_ni} = 2'b11;
    #2 rst_ni = 1'b0;
    #1 chk("R1 async reset", q_o, 8'h00);
    mdl = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(2'b11, 3'd0, 1'b1);
    chk("R1 after reset hold", q_o, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule